// File: doc/BRIEF.md
# Factory Bad-Block Scanner

This block walks every erase block of a NAND array once after power-up and records which blocks were shipped defective. For each block it asks an external operation sequencer for single bytes taken from the start of the spare area. A block whose marker byte is anything other than the erased value FFh is recorded as bad. The verdicts go into a one-bit-per-block table. Firmware or a mapping layer queries that table through a lookup port once the walk is finished.

The block must run before anything erases the array, because an erase wipes out the markers. One start pulse launches the walk. The busy flag covers the walk, and the done flag then stays up. At the end the block reports the number of bad blocks, an over-limit flag for a device that exceeds its allowed number of bad blocks, and a sticky flag for sequencer faults seen during the walk.

Top module: `bbs_scanner`

## Requirements
- R1: For every block b other than block 0, the first request is to row b*PAGES_PER_BLOCK (page 0), and every request carries column MARK_COL (default 2048, the first spare byte).
- R2: A second request, to row b*PAGES_PER_BLOCK+1 (page 1), is issued only when the page-0 byte was FFh without error. No request ever addresses a page above 1.
- R3: A block is recorded bad (table bit 1) when any byte it returned differs from FFh. A block whose page-0 and page-1 bytes are both FFh is recorded good (bit 0).
- R4: Block 0 is never read and is always recorded good, whatever its markers contain.
- R5: A response flagged as an error, or no response within TIMEOUT_CYC cycles after a request is accepted, marks that block bad and sets scan_err. scan_err stays set until the next accepted start.
- R6: A request (seq_req_valid high) keeps its row and column unchanged until the cycle in which seq_req_ready is high.
- R7: scan_busy rises in the cycle after an accepted start and stays high until scan_done rises. scan_done then holds until the next start. A start pulse while busy has no effect.
- R8: Each lookup request is answered one cycle later with lk_ack. While the walk is running, or before any walk has finished, the answer is lk_reject=1 with lk_bad=0. Otherwise lk_bad gives the recorded bit for lk_blk.
- R9: After the walk, bad_count equals the number of blocks recorded bad, and bad_over_limit is 1 exactly when bad_count exceeds MAX_BAD (default 80).
- R10: After reset, scan_busy, scan_done, scan_err, bad_count, bad_over_limit and seq_req_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_start | input | 1 | Pulse to begin a walk (ignored while busy) |
| scan_busy | output | 1 | Walk in progress |
| scan_done | output | 1 | Walk finished, table valid |
| scan_err | output | 1 | Sticky: sequencer error or timeout during the walk |
| bad_count | output | $clog2(NUM_BLOCKS+1) | Number of blocks recorded bad |
| bad_over_limit | output | 1 | bad_count greater than MAX_BAD |
| seq_req_valid | output | 1 | Single-byte read request to the sequencer |
| seq_req_ready | input | 1 | Sequencer accepts the request |
| seq_req_row | output | $clog2(NUM_BLOCKS*PAGES_PER_BLOCK) | Page (row) address of the read |
| seq_req_col | output | COL_W | Column of the read |
| seq_rsp_valid | input | 1 | Response byte present (after the device reports ready) |
| seq_rsp_byte | input | 8 | Byte read |
| seq_rsp_err | input | 1 | Sequencer reports a failed read |
| lk_req | input | 1 | Table lookup request |
| lk_blk | input | $clog2(NUM_BLOCKS) | Block to look up |
| lk_ack | output | 1 | Lookup answer present |
| lk_bad | output | 1 | Looked-up block is bad |
| lk_reject | output | 1 | Lookup refused (walk running or never run) |

## Verification
Several marker patterns are applied to the same array. In the all-erased pattern, every block must be read twice. Page-0-only defects, using values such as 00h, FEh and 7Fh, must stop each walk after one read. Page-1-only defects show whether the second read is judged at all. Block 0 is loaded with bad markers, which must be ignored. Runs with exactly MAX_BAD and MAX_BAD+1 bad blocks separate the limit comparison from an off-by-one. Error and silent responses exercise the timeout and the sticky flag. A second start issued in the middle of a walk would show up as repeated reads of early blocks.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECORD,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_t;

  localparam logic [7:0] ERASED_MARK = 8'hFF;

endpackage

// File: rtl/bbs_walker.sv
module bbs_walker
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COL_W           = 12,
  parameter int MARK_COL        = 2048,
  parameter int TIMEOUT_CYC     = 4096
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start_i,
  output logic                                          seq_req_valid_o,
  input  logic                                          seq_req_ready_i,
  output logic [$clog2(NUM_BLOCKS*PAGES_PER_BLOCK)-1:0] seq_row_o,
  output logic [COL_W-1:0]                              seq_col_o,
  input  logic                                          seq_rsp_valid_i,
  input  logic [7:0]                                    seq_rsp_byte_i,
  input  logic                                          seq_rsp_err_i,
  output logic                                          rec_en_o,
  output logic [$clog2(NUM_BLOCKS)-1:0]                 rec_blk_o,
  output logic                                          rec_bad_o,
  output logic                                          clear_o,
  output logic                                          busy_o,
  output logic                                          done_o,
  output logic                                          scan_err_o
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  walk_state_t        st_q, st_d;
  logic [BLK_W-1:0]   blk_q, blk_d;
  logic               page_q, page_d;
  logic               bad_q, bad_d;
  logic               err_q, err_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;

  logic start_ok;
  logic tmr_end;
  logic last_blk;
  logic mark_erased;

  assign start_ok    = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign tmr_end     = (tmr_q == TMR_W'(TIMEOUT_CYC - 1));
  assign last_blk    = (blk_q == BLK_W'(NUM_BLOCKS - 1));
  assign mark_erased = (seq_rsp_byte_i == ERASED_MARK) && !seq_rsp_err_i;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    blk_d  = blk_q;
    page_d = page_q;
    bad_d  = bad_q;
    err_d  = err_q;
    tmr_d  = tmr_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_ok) begin
          // block 0 goes straight to recording as good
          blk_d  = '0;
          page_d = 1'b0;
          bad_d  = 1'b0;
          err_d  = 1'b0;
          st_d   = ST_RECORD;
        end
      end
      ST_RECORD: begin
        if (last_blk) begin
          st_d = ST_DONE;
        end else begin
          blk_d  = blk_q + BLK_W'(1);
          page_d = 1'b0;
          bad_d  = 1'b0;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (seq_req_ready_i) begin
          tmr_d = '0;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (seq_rsp_valid_i) begin
          if (!mark_erased) begin
            bad_d = 1'b1;
            err_d = err_q | seq_rsp_err_i;
            st_d  = ST_RECORD;
          end else if (!page_q) begin
            page_d = 1'b1;
            st_d   = ST_ISSUE;
          end else begin
            st_d = ST_RECORD;
          end
        end else if (tmr_end) begin
          bad_d = 1'b1;
          err_d = 1'b1;
          st_d  = ST_RECORD;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      blk_q  <= '0;
      page_q <= 1'b0;
      bad_q  <= 1'b0;
      err_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      page_q <= page_d;
      bad_q  <= bad_d;
      err_q  <= err_d;
      tmr_q  <= tmr_d;
    end
  end

  assign seq_req_valid_o = (st_q == ST_ISSUE);
  assign seq_row_o       = ROW_W'(blk_q) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(page_q);
  assign seq_col_o       = COL_W'(MARK_COL);
  assign rec_en_o        = (st_q == ST_RECORD);
  assign rec_blk_o       = blk_q;
  assign rec_bad_o       = bad_q;
  assign clear_o         = start_ok;
  assign busy_o          = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o          = (st_q == ST_DONE);
  assign scan_err_o      = err_q;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req_valid_o && !seq_req_ready_i |=> seq_req_valid_o && $stable(seq_row_o));

  p_no_block0_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req_valid_o |-> (int'(seq_row_o) >= PAGES_PER_BLOCK));

  p_page_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req_valid_o |-> ((int'(seq_row_o) % PAGES_PER_BLOCK) < 2));

  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_err_o && !clear_o |=> scan_err_o);

  p_timeout_marks_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) && tmr_end && !seq_rsp_valid_i |=> rec_en_o && rec_bad_o && scan_err_o);

endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
  parameter int NUM_BLOCKS = 4096,
  parameter int WORD_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] wr_blk_i,
  input  logic                          wr_bad_i,
  input  logic                          table_ok_i,
  input  logic                          lk_req_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] lk_blk_i,
  output logic                          lk_ack_o,
  output logic                          lk_bad_o,
  output logic                          lk_reject_o
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int DEPTH = (NUM_BLOCKS + WORD_W - 1) / WORD_W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];

  logic [AW-1:0]    wr_word, lk_word;
  logic [BIT_W-1:0] wr_bit, lk_bit;

  assign wr_word = AW'(wr_blk_i >> BIT_W);
  assign wr_bit  = wr_blk_i[BIT_W-1:0];
  assign lk_word = AW'(lk_blk_i >> BIT_W);
  assign lk_bit  = lk_blk_i[BIT_W-1:0];

  // table storage: no reset, every bit is written during a walk
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_word][wr_bit] <= wr_bad_i;
    end
  end

  logic ack_d, bad_d, rej_d;
  logic ack_q, bad_q, rej_q;

  always_comb begin
    ack_d = lk_req_i;
    rej_d = lk_req_i && !table_ok_i;
    bad_d = lk_req_i && table_ok_i && mem[lk_word][lk_bit];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      bad_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      bad_q <= bad_d;
      rej_q <= rej_d;
    end
  end

  assign lk_ack_o    = ack_q;
  assign lk_bad_o    = bad_q;
  assign lk_reject_o = rej_q;

  p_reject_unready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i && !table_ok_i |=> lk_ack_o && lk_reject_o && !lk_bad_o);

  p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack_o |-> $past(lk_req_i));

  p_no_write_when_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !table_ok_i);

endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
  parameter int NUM_BLOCKS = 4096,
  parameter int MAX_BAD    = 80
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear_i,
  input  logic                            inc_i,
  output logic [$clog2(NUM_BLOCKS+1)-1:0] count_o,
  output logic                            over_o
);

  localparam int CNT_W = $clog2(NUM_BLOCKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign over_o  = (cnt_q > CNT_W'(MAX_BAD));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));

  p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0) && !over_o);

endmodule

// File: rtl/bbs_scanner.sv
module bbs_scanner #(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COL_W           = 12,
  parameter int MARK_COL        = 2048,
  parameter int MAX_BAD         = 80,
  parameter int TIMEOUT_CYC     = 4096,
  parameter int WORD_W          = 32
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          scan_start,
  output logic                                          scan_busy,
  output logic                                          scan_done,
  output logic                                          scan_err,
  output logic [$clog2(NUM_BLOCKS+1)-1:0]               bad_count,
  output logic                                          bad_over_limit,
  output logic                                          seq_req_valid,
  input  logic                                          seq_req_ready,
  output logic [$clog2(NUM_BLOCKS*PAGES_PER_BLOCK)-1:0] seq_req_row,
  output logic [COL_W-1:0]                              seq_req_col,
  input  logic                                          seq_rsp_valid,
  input  logic [7:0]                                    seq_rsp_byte,
  input  logic                                          seq_rsp_err,
  input  logic                                          lk_req,
  input  logic [$clog2(NUM_BLOCKS)-1:0]                 lk_blk,
  output logic                                          lk_ack,
  output logic                                          lk_bad,
  output logic                                          lk_reject
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic             rec_en, rec_bad, clear;
  logic [BLK_W-1:0] rec_blk;

  bbs_walker #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .COL_W           (COL_W),
    .MARK_COL        (MARK_COL),
    .TIMEOUT_CYC     (TIMEOUT_CYC)
  ) u_walker (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .start_i         (scan_start),
    .seq_req_valid_o (seq_req_valid),
    .seq_req_ready_i (seq_req_ready),
    .seq_row_o       (seq_req_row),
    .seq_col_o       (seq_req_col),
    .seq_rsp_valid_i (seq_rsp_valid),
    .seq_rsp_byte_i  (seq_rsp_byte),
    .seq_rsp_err_i   (seq_rsp_err),
    .rec_en_o        (rec_en),
    .rec_blk_o       (rec_blk),
    .rec_bad_o       (rec_bad),
    .clear_o         (clear),
    .busy_o          (scan_busy),
    .done_o          (scan_done),
    .scan_err_o      (scan_err)
  );

  bbs_bitmap #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .WORD_W     (WORD_W)
  ) u_bitmap (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en_i     (rec_en),
    .wr_blk_i    (rec_blk),
    .wr_bad_i    (rec_bad),
    .table_ok_i  (scan_done),
    .lk_req_i    (lk_req),
    .lk_blk_i    (lk_blk),
    .lk_ack_o    (lk_ack),
    .lk_bad_o    (lk_bad),
    .lk_reject_o (lk_reject)
  );

  bbs_tally #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .MAX_BAD    (MAX_BAD)
  ) u_tally (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clear_i (clear),
    .inc_i   (rec_en && rec_bad),
    .count_o (bad_count),
    .over_o  (bad_over_limit)
  );

endmodule

// File: tb/bbs_scanner_tb.sv
`timescale 1ns/1ps
module bbs_scanner_tb;

  localparam int NB        = 64;
  localparam int PP        = 64;
  localparam int MAXB      = 5;
  localparam int TO        = 40;
  localparam int READY_DLY = 2;
  localparam int LAT       = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_start;
  logic        scan_busy, scan_done, scan_err;
  logic [6:0]  bad_count;
  logic        bad_over_limit;
  logic        seq_req_valid, seq_req_ready;
  logic [11:0] seq_req_row;
  logic [11:0] seq_req_col;
  logic        seq_rsp_valid;
  logic [7:0]  seq_rsp_byte;
  logic        seq_rsp_err;
  logic        lk_req;
  logic [5:0]  lk_blk;
  logic        lk_ack, lk_bad, lk_reject;

  always #2 clk = ~clk;

  bbs_scanner #(
    .NUM_BLOCKS      (NB),
    .PAGES_PER_BLOCK (PP),
    .COL_W           (12),
    .MARK_COL        (2048),
    .MAX_BAD         (MAXB),
    .TIMEOUT_CYC     (TO),
    .WORD_W          (32)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_start     (scan_start),
    .scan_busy      (scan_busy),
    .scan_done      (scan_done),
    .scan_err       (scan_err),
    .bad_count      (bad_count),
    .bad_over_limit (bad_over_limit),
    .seq_req_valid  (seq_req_valid),
    .seq_req_ready  (seq_req_ready),
    .seq_req_row    (seq_req_row),
    .seq_req_col    (seq_req_col),
    .seq_rsp_valid  (seq_rsp_valid),
    .seq_rsp_byte   (seq_rsp_byte),
    .seq_rsp_err    (seq_rsp_err),
    .lk_req         (lk_req),
    .lk_blk         (lk_blk),
    .lk_ack         (lk_ack),
    .lk_bad         (lk_bad),
    .lk_reject      (lk_reject)
  );

  // marker image of the array and sequencer behaviour per block
  logic [7:0] pg0 [NB];
  logic [7:0] pg1 [NB];
  bit         err0 [NB];
  bit         mute0 [NB];

  int reads [NB];
  int col_viol, page_viol, stab_viol, range_viol;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // sequencer model
  initial begin
    seq_req_ready = 1'b0;
    seq_rsp_valid = 1'b0;
    seq_rsp_byte  = 8'h00;
    seq_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && seq_req_valid) begin
        int row, b, p;
        row = int'(seq_req_row);
        b   = row / PP;
        p   = row % PP;
        if (seq_req_col != 12'd2048) col_viol++;
        if (p > 1) page_viol++;
        if (b < NB) reads[b]++; else range_viol++;
        repeat (READY_DLY) begin
          @(negedge clk);
          if (!seq_req_valid || int'(seq_req_row) != row) stab_viol++;
        end
        seq_req_ready = 1'b1;
        @(negedge clk);
        seq_req_ready = 1'b0;
        if (!(b < NB && p == 0 && mute0[b])) begin
          repeat (LAT) @(negedge clk);
          seq_rsp_valid = 1'b1;
          seq_rsp_err   = (b < NB) && (p == 0) && err0[b];
          seq_rsp_byte  = (b >= NB) ? 8'hFF : ((p == 0) ? pg0[b] : pg1[b]);
          @(negedge clk);
          seq_rsp_valid = 1'b0;
          seq_rsp_err   = 1'b0;
        end
      end
    end
  end

  function automatic int exp_reads(input int b);
    if (b == 0) return 0;
    if (err0[b] || mute0[b] || pg0[b] != 8'hFF) return 1;
    return 2;
  endfunction

  function automatic bit exp_bad(input int b);
    if (b == 0) return 1'b0;
    return err0[b] || mute0[b] || pg0[b] != 8'hFF || pg1[b] != 8'hFF;
  endfunction

  task automatic erase_image();
    for (int b = 0; b < NB; b++) begin
      pg0[b] = 8'hFF; pg1[b] = 8'hFF; err0[b] = 1'b0; mute0[b] = 1'b0;
    end
  endtask

  task automatic lookup(input int b, output bit ack, output bit rej, output bit bad);
    @(negedge clk);
    lk_req = 1'b1;
    lk_blk = 6'(b);
    @(negedge clk);
    lk_req = 1'b0;
    ack = lk_ack; rej = lk_reject; bad = lk_bad;
  endtask

  task automatic launch();
    for (int b = 0; b < NB; b++) reads[b] = 0;
    col_viol = 0; page_viol = 0; stab_viol = 0; range_viol = 0;
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    chk(scan_busy && !scan_done, "R7 busy after start", int'(scan_busy), 1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!scan_done && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (scan_busy && scan_done) chk(1'b0, "R7 busy and done together", 1, 0);
    end
    chk(scan_done && !scan_busy, "R7 done reached", int'(scan_done), 1);
  endtask

  task automatic verify(input string tag);
    int  nbad = 0;
    bit  anyerr = 1'b0;
    int  rmis = 0, bmis = 0;
    bit  ack, rej, bad;
    for (int b = 0; b < NB; b++) begin
      if (reads[b] != exp_reads(b)) begin
        rmis++;
        chk(1'b0, $sformatf("R2 %s reads of block %0d", tag, b), reads[b], exp_reads(b));
      end
      lookup(b, ack, rej, bad);
      if (!ack || rej || bad != exp_bad(b)) begin
        bmis++;
        chk(1'b0, $sformatf("R3 %s table bit of block %0d", tag, b), int'(bad), int'(exp_bad(b)));
      end
      if (exp_bad(b)) nbad++;
      if (err0[b] || mute0[b]) anyerr = 1'b1;
    end
    chk(rmis == 0, {"R1 R2 read pattern ", tag}, rmis, 0);
    chk(bmis == 0, {"R3 table contents ", tag}, bmis, 0);
    chk(reads[0] == 0, {"R4 block 0 not read ", tag}, reads[0], 0);
    lookup(0, ack, rej, bad);
    chk(ack && !rej && !bad, {"R4 block 0 good ", tag}, int'(bad), 0);
    chk(col_viol == 0, {"R1 column 2048 ", tag}, col_viol, 0);
    chk(page_viol == 0 && range_viol == 0, {"R2 page index <= 1 ", tag}, page_viol + range_viol, 0);
    chk(stab_viol == 0, {"R6 request stable ", tag}, stab_viol, 0);
    chk(int'(bad_count) == nbad, {"R9 bad count ", tag}, int'(bad_count), nbad);
    chk(bad_over_limit == (nbad > MAXB), {"R9 over limit ", tag}, int'(bad_over_limit), int'(nbad > MAXB));
    chk(scan_err == anyerr, {"R5 scan error flag ", tag}, int'(scan_err), int'(anyerr));
  endtask

  task automatic t_reset();
    bit ack, rej, bad;
    chk(!scan_busy && !scan_done && !scan_err, "R10 flags after reset",
        int'({scan_busy, scan_done, scan_err}), 0);
    chk(bad_count == 0 && !bad_over_limit, "R10 count after reset", int'(bad_count), 0);
    chk(!seq_req_valid, "R10 no request after reset", int'(seq_req_valid), 0);
    lookup(5, ack, rej, bad);
    chk(ack && rej && !bad, "R8 lookup rejected before any scan", int'(rej), 1);
  endtask

  task automatic t_all_erased();
    erase_image();
    launch();
    wait_done();
    verify("all erased");
  endtask

  task automatic t_mixed();
    erase_image();
    pg0[0] = 8'h00; pg1[0] = 8'h00;       // block 0 must still be good
    pg0[3] = 8'h00;
    pg0[10] = 8'hFE;
    pg1[17] = 8'h7F;                       // only page 1 marked
    pg1[40] = 8'h00;
    pg0[63] = 8'h0F;                       // last block
    launch();
    wait_done();
    verify("mixed");
  endtask

  task automatic t_limit();
    erase_image();
    for (int i = 1; i <= MAXB; i++) pg0[i * 7] = 8'h00;
    launch();
    wait_done();
    verify("at limit");
    chk(!bad_over_limit, "R9 exactly MAX_BAD not over", int'(bad_over_limit), 0);
    pg1[50] = 8'hAA;
    launch();
    wait_done();
    verify("over limit");
    chk(bad_over_limit, "R9 MAX_BAD+1 over", int'(bad_over_limit), 1);
  endtask

  task automatic t_faults();
    erase_image();
    err0[7]  = 1'b1;                       // error with an erased byte
    mute0[9] = 1'b1;                       // never answers
    launch();
    wait_done();
    verify("faults");
    repeat (5) @(negedge clk);
    chk(scan_err, "R5 error flag held after done", int'(scan_err), 1);
    erase_image();
    launch();
    chk(!scan_err, "R5 error flag cleared by start", int'(scan_err), 0);
    wait_done();
    verify("clean after faults");
  endtask

  task automatic t_busy();
    bit ack, rej, bad;
    erase_image();
    pg0[2] = 8'h00;
    launch();
    repeat (20) @(negedge clk);
    chk(scan_busy && !scan_done, "R7 still busy mid walk", int'(scan_busy), 1);
    lookup(2, ack, rej, bad);
    chk(ack && rej && !bad, "R8 lookup rejected while busy", int'(rej), 1);
    @(negedge clk);
    scan_start = 1'b1;                     // must be ignored
    @(negedge clk);
    scan_start = 1'b0;
    wait_done();
    verify("restart ignored");
    lookup(2, ack, rej, bad);
    chk(ack && !rej && bad, "R8 lookup after done", int'(bad), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    scan_start = 1'b0;
    lk_req     = 1'b0;
    lk_blk     = '0;
    erase_image();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_all_erased();
    t_mixed();
    t_limit();
    t_faults();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule